// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the wall-clock time and calendar date for a low-power timekeeping domain. It runs on the 32.768 kHz reference clock. A prescaler of `DIV_W` bits divides that clock down to one update per second. On each update the BCD counters for seconds, minutes, hours, day of month, weekday, month and a two-digit year advance, and a carry passes from each counter to the next. The day counter follows the length of the current month. February has 29 days when the two-digit year is a multiple of four, and year 00 counts as such a year. A century bit toggles each time the year wraps from 99 to 00.

Software sets the time through a simple write port: an enable, a 3-bit field select and a byte of data. Every field can be read at any time on its own output port. A write to any time field clears the sub-second count, so the next update comes one full second after the write. A stop input holds the prescaler at a preload value. When stop is released, the first update comes a little more than half a second later. A sticky voltage-low flag records that a supply monitor outside this block reported low voltage. Only a write to the status field can clear it.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the outputs read 00:00:00, day 01, weekday 0, month 01, year 00, century 0, and the voltage-low flag reads 1.
- R2: While stop is low, seconds advance once every 2^DIV_W clock cycles. A write to a time field (select 0 to 6) clears the sub-second count. The next increment then comes exactly 2^DIV_W cycles after the write edge. An update that falls on the same edge as the write is dropped.
- R3: Seconds and minutes count 00 to 59 and hours count 00 to 23, each in BCD. A wrap of seconds advances minutes, and a wrap of minutes advances hours. A wrap of hours advances both the day and the weekday. The weekday counts 0 to 6 in binary.
- R4: The day wraps to 01 and the month advances after day 31 in months 01, 03, 05, 07, 08, 10 and 12. The same happens after day 30 in months 04, 06, 09 and 11. The month wraps from 12 to 01, and that wrap advances the year.
- R5: In February the day wraps after 29 when the BCD year is a multiple of four (00 included) and after 28 otherwise.
- R6: The year counts 00 to 99 in BCD. When it wraps from 99 to 00 the century bit inverts. At no other time does the century bit change, except through a write to the month field.
- R7: While stop is high the time does not advance. After stop falls, the first seconds increment comes 2^(DIV_W-1) + 2^(DIV_W-7) cycles later. That is 16640 cycles, about 0.5078 s, for DIV_W = 15.
- R8: The voltage-low flag is set in the cycle after vlow_i is high. A write to select 7 with data bit 0 = 0 clears it. A write to select 7 with bit 0 = 1 leaves the flag unchanged. When a clear and vlow_i coincide, the set wins.
- R9: Write field selects are: 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month (data bit 7 is the century, bits 4:0 the BCD month), 6 year, 7 status. A written value appears on the outputs after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz reference clock (prescaler input) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Holds the prescaler and freezes timekeeping |
| vlow_i | input | 1 | Low-supply indication from an external monitor, synchronous |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Write data, BCD |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD |
| day_o | output | 6 | Day of month, BCD |
| wday_o | output | 3 | Weekday 0 to 6 |
| mon_o | output | 5 | Month, BCD |
| cent_o | output | 1 | Century bit |
| year_o | output | 8 | Year, BCD |
| vl_o | output | 1 | Sticky voltage-low flag |

## Verification
The range assertions assume that every field write carries a legal BCD value inside that field's range. They also assume that a written day does not exceed the length of the written month. The bench only writes such consistent dates, and it sets all seven time fields before each rollover it examines. The stop and century properties assume that writes are the only other source of change, so they are conditioned on the write strobe being low. The bench keeps the strobe low during every wait it measures.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DAY  = 3'd3,
    FLD_WDAY = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_STAT = 3'd7
  } fld_e;

  localparam int unsigned NUM_FLD = 8;

  // Divisible by four on BCD: tens parity selects which units digits qualify
  function automatic logic leap_year(input logic [4:0] yr_lo);
    if (yr_lo[4]) return (yr_lo[3:0] == 4'd2) || (yr_lo[3:0] == 4'd6);
    return (yr_lo[3:0] == 4'd0) || (yr_lo[3:0] == 4'd4) || (yr_lo[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [4:0] yr_lo);
    case (mon)
      5'h02:                      return leap_year(yr_lo) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_W = 15  // must be >= 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam logic [DIV_W-1:0] ALL_ONES = '1;
  // first tick after stop release lands HALF + HALF/64 cycles later
  localparam logic [DIV_W-1:0] PRELOAD  =
    DIV_W'((64'd1 << (DIV_W-1)) - (64'd1 << (DIV_W-7)));

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (stop_i) cnt_q <= PRELOAD;
    else if (clr_i)  cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !stop_i && !clr_i && (cnt_q == ALL_ONES);

endmodule

// File: rtl/rtc_field_cnt.sv
module rtc_field_cnt #(
  parameter int unsigned     W       = 7,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  logic [W-1:0] val_q, nxt_val;
  logic         at_top;

  generate
    if (W > 4) begin : g_bcd
      always_comb begin
        if (val_q[3:0] == 4'd9) nxt_val = {val_q[W-1:4] + 1'b1, 4'h0};
        else                    nxt_val = {val_q[W-1:4], val_q[3:0] + 4'h1};
      end
    end else begin : g_bin
      always_comb nxt_val = val_q + 1'b1;
    end
  endgenerate

  // >= so an out-of-range value left by a month change still wraps
  assign at_top  = (val_q >= hi_i);
  assign carry_o = inc_i && !ld_i && at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST_VAL;
    else if (ld_i)   val_q <= ld_val_i;
    else if (inc_i)  val_q <= at_top ? lo_i : nxt_val;
  end

  assign val_o = val_q;

endmodule

// File: rtl/rtc_vl_flag.sv
module rtc_vl_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b1;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_i,
  input  logic       vlow_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic [5:0] day_o,
  output logic [2:0] wday_o,
  output logic [4:0] mon_o,
  output logic       cent_o,
  output logic [7:0] year_o,
  output logic       vl_o
);
  logic [NUM_FLD-1:0] fld_ld;
  logic time_wr, tick;
  logic c_sec, c_min, c_hour, c_day, c_mon, c_year, c_wday;
  logic [5:0] day_max;
  logic cent_q;

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_ld
    assign fld_ld[g] = wr_en_i && (wr_addr_i == 3'(g));
  end

  assign time_wr = |fld_ld[FLD_YEAR:FLD_SEC];
  assign day_max = month_len(mon_o, year_o[4:0]);

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i, .rst_ni, .stop_i, .clr_i(time_wr), .tick_o(tick)
  );

  rtc_field_cnt #(.W(7), .RST_VAL(7'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(tick), .ld_i(fld_ld[FLD_SEC]), .ld_val_i(wr_data_i[6:0]),
    .lo_i(7'h00), .hi_i(7'h59), .val_o(sec_o), .carry_o(c_sec)
  );

  rtc_field_cnt #(.W(7), .RST_VAL(7'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(c_sec), .ld_i(fld_ld[FLD_MIN]), .ld_val_i(wr_data_i[6:0]),
    .lo_i(7'h00), .hi_i(7'h59), .val_o(min_o), .carry_o(c_min)
  );

  rtc_field_cnt #(.W(6), .RST_VAL(6'h00)) u_hour (
    .clk_i, .rst_ni, .inc_i(c_min), .ld_i(fld_ld[FLD_HOUR]), .ld_val_i(wr_data_i[5:0]),
    .lo_i(6'h00), .hi_i(6'h23), .val_o(hour_o), .carry_o(c_hour)
  );

  rtc_field_cnt #(.W(6), .RST_VAL(6'h01)) u_day (
    .clk_i, .rst_ni, .inc_i(c_hour), .ld_i(fld_ld[FLD_DAY]), .ld_val_i(wr_data_i[5:0]),
    .lo_i(6'h01), .hi_i(day_max), .val_o(day_o), .carry_o(c_day)
  );

  rtc_field_cnt #(.W(3), .RST_VAL(3'd0)) u_wday (
    .clk_i, .rst_ni, .inc_i(c_hour), .ld_i(fld_ld[FLD_WDAY]), .ld_val_i(wr_data_i[2:0]),
    .lo_i(3'd0), .hi_i(3'd6), .val_o(wday_o), .carry_o(c_wday)
  );

  rtc_field_cnt #(.W(5), .RST_VAL(5'h01)) u_mon (
    .clk_i, .rst_ni, .inc_i(c_day), .ld_i(fld_ld[FLD_MON]), .ld_val_i(wr_data_i[4:0]),
    .lo_i(5'h01), .hi_i(5'h12), .val_o(mon_o), .carry_o(c_mon)
  );

  rtc_field_cnt #(.W(8), .RST_VAL(8'h00)) u_year (
    .clk_i, .rst_ni, .inc_i(c_mon), .ld_i(fld_ld[FLD_YEAR]), .ld_val_i(wr_data_i),
    .lo_i(8'h00), .hi_i(8'h99), .val_o(year_o), .carry_o(c_year)
  );

  // weekday carry has no consumer; the week is not a calendar level
  logic unused_wday_carry;
  assign unused_wday_carry = c_wday;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cent_q <= 1'b0;
    else if (fld_ld[FLD_MON])  cent_q <= wr_data_i[7];
    else if (c_year)           cent_q <= ~cent_q;
  end
  assign cent_o = cent_q;

  rtc_vl_flag u_vl (
    .clk_i, .rst_ni, .set_i(vlow_i),
    .clr_i(fld_ld[FLD_STAT] && !wr_data_i[0]), .flag_o(vl_o)
  );

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       vlow_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [6:0] sec_o,
  input logic [6:0] min_o,
  input logic [5:0] hour_o,
  input logic [5:0] day_o,
  input logic [2:0] wday_o,
  input logic [4:0] mon_o,
  input logic       cent_o,
  input logic [7:0] year_o,
  input logic       vl_o
);
  // R3
  sec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o[3:0] <= 4'd9) && (sec_o <= 7'h59));
  // R3
  min_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_o[3:0] <= 4'd9) && (min_o <= 7'h59));
  // R3
  hour_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hour_o[3:0] <= 4'd9) && (hour_o <= 6'h23));
  // R3
  wday_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wday_o <= 3'd6);
  // R4
  day_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_o != 6'h00) && (day_o[3:0] <= 4'd9) && (day_o <= 6'h31));
  // R4
  mon_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_o != 5'h00) && (mon_o[3:0] <= 4'd9) && (mon_o <= 5'h12));
  // R5
  feb_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_o == 5'h02) |-> (day_o <= 6'h29));
  // R6
  cent_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && (year_o != 8'h99)) |=> $stable(cent_o));
  // R7
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_en_i) |=> $stable({sec_o, min_o, hour_o, day_o, wday_o, mon_o, year_o}));
  // R8
  vl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vlow_i |=> vl_o);
  // R8
  vl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vl_o && !(wr_en_i && (wr_addr_i == 3'd7))) |=> vl_o);

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk_i, .rst_ni, .stop_i, .vlow_i, .wr_en_i, .wr_addr_i,
  .sec_o, .min_o, .hour_o, .day_o, .wday_o, .mon_o, .cent_o, .year_o, .vl_o
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int SEC_CYC    = 1 << DIV_W;
  localparam int START_CYC  = (1 << (DIV_W-1)) + (1 << (DIV_W-7));

  logic       clk = 1'b0, rst_ni = 1'b0, stop_i = 1'b0, vlow_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [6:0] sec_o, min_o;
  logic [5:0] hour_o, day_o;
  logic [2:0] wday_o;
  logic [4:0] mon_o;
  logic       cent_o, vl_o;
  logic [7:0] year_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core #(.DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni, .stop_i, .vlow_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .sec_o, .min_o, .hour_o, .day_o, .wday_o, .mon_o, .cent_o, .year_o, .vl_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // packed as {hour,min,sec,day,wday,cent,mon,year}
  function automatic logic [63:0] now();
    return {21'd0, hour_o, min_o, sec_o, day_o, wday_o, cent_o, mon_o, year_o};
  endfunction

  function automatic logic [63:0] pk(input logic [5:0] h, input logic [6:0] m, input logic [6:0] s,
      input logic [5:0] d, input logic [2:0] w, input logic c, input logic [4:0] mo, input logic [7:0] y);
    return {21'd0, h, m, s, d, w, c, mo, y};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_all(input logic [5:0] h, input logic [6:0] m, input logic [6:0] s,
      input logic [5:0] d, input logic [2:0] w, input logic c, input logic [4:0] mo, input logic [7:0] y);
    wr(3'd6, y);
    wr(3'd5, {c, 2'b00, mo});
    wr(3'd3, {2'b00, d});
    wr(3'd4, {5'd0, w});
    wr(3'd2, {2'b00, h});
    wr(3'd1, {1'b0, m});
    wr(3'd0, {1'b0, s});
  endtask

  // set a time, let exactly one second elapse, compare
  task automatic step(input string req, input logic [63:0] start, input logic [63:0] exp);
    set_all(start[42:37], start[36:30], start[29:23], start[22:17], start[16:14],
            start[13], start[12:8], start[7:0]);
    repeat (SEC_CYC) @(negedge clk);
    chk(req, now(), exp);
  endtask

  task automatic t_reset();
    chk("R1 time", now(), pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd0, 1'b0, 5'h01, 8'h00));
    chk("R1 vl", 64'(vl_o), 64'd1);
  endtask

  task automatic t_second_timing();
    wr(3'd0, 8'h58);
    chk("R9 write visible", 64'(sec_o), 64'h58);
    repeat (SEC_CYC-1) @(negedge clk);
    chk("R2 no early tick", 64'(sec_o), 64'h58);
    @(negedge clk);
    chk("R2 tick on period", 64'(sec_o), 64'h59);
    repeat (SEC_CYC) @(negedge clk);
    chk("R2 second period", {57'd0, min_o}, 64'h01);
    repeat (SEC_CYC/2) @(negedge clk);
    wr(3'd0, 8'h10);
    repeat (SEC_CYC-1) @(negedge clk);
    chk("R2 write restarts count", 64'(sec_o), 64'h10);
    @(negedge clk);
    chk("R2 write restart tick", 64'(sec_o), 64'h11);
  endtask

  task automatic t_carry();
    step("R3 bcd hour digit", pk(6'h09, 7'h59, 7'h59, 6'h05, 3'd3, 1'b0, 5'h03, 8'h21),
                              pk(6'h10, 7'h00, 7'h00, 6'h05, 3'd3, 1'b0, 5'h03, 8'h21));
    step("R3 midnight", pk(6'h23, 7'h59, 7'h59, 6'h15, 3'd6, 1'b0, 5'h03, 8'h21),
                        pk(6'h00, 7'h00, 7'h00, 6'h16, 3'd0, 1'b0, 5'h03, 8'h21));
    step("R3 minute only", pk(6'h14, 7'h29, 7'h59, 6'h15, 3'd2, 1'b0, 5'h03, 8'h21),
                           pk(6'h14, 7'h30, 7'h00, 6'h15, 3'd2, 1'b0, 5'h03, 8'h21));
  endtask

  task automatic t_month();
    step("R4 april 30", pk(6'h23, 7'h59, 7'h59, 6'h30, 3'd1, 1'b0, 5'h04, 8'h21),
                        pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd2, 1'b0, 5'h05, 8'h21));
    step("R4 jan 31", pk(6'h23, 7'h59, 7'h59, 6'h31, 3'd1, 1'b0, 5'h01, 8'h21),
                      pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd2, 1'b0, 5'h02, 8'h21));
    step("R4 aug 30 not end", pk(6'h23, 7'h59, 7'h59, 6'h30, 3'd1, 1'b0, 5'h08, 8'h21),
                              pk(6'h00, 7'h00, 7'h00, 6'h31, 3'd2, 1'b0, 5'h08, 8'h21));
    step("R4 nov 30", pk(6'h23, 7'h59, 7'h59, 6'h30, 3'd4, 1'b0, 5'h11, 8'h21),
                      pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd5, 1'b0, 5'h12, 8'h21));
  endtask

  task automatic t_leap();
    step("R5 year 24 feb 28", pk(6'h23, 7'h59, 7'h59, 6'h28, 3'd0, 1'b0, 5'h02, 8'h24),
                              pk(6'h00, 7'h00, 7'h00, 6'h29, 3'd1, 1'b0, 5'h02, 8'h24));
    step("R5 year 24 feb 29", pk(6'h23, 7'h59, 7'h59, 6'h29, 3'd0, 1'b0, 5'h02, 8'h24),
                              pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd1, 1'b0, 5'h03, 8'h24));
    step("R5 year 00 leap", pk(6'h23, 7'h59, 7'h59, 6'h28, 3'd0, 1'b1, 5'h02, 8'h00),
                            pk(6'h00, 7'h00, 7'h00, 6'h29, 3'd1, 1'b1, 5'h02, 8'h00));
    step("R5 year 12 leap", pk(6'h23, 7'h59, 7'h59, 6'h28, 3'd0, 1'b0, 5'h02, 8'h12),
                            pk(6'h00, 7'h00, 7'h00, 6'h29, 3'd1, 1'b0, 5'h02, 8'h12));
    step("R5 year 10 common", pk(6'h23, 7'h59, 7'h59, 6'h28, 3'd0, 1'b0, 5'h02, 8'h10),
                              pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd1, 1'b0, 5'h03, 8'h10));
    step("R5 year 23 common", pk(6'h23, 7'h59, 7'h59, 6'h28, 3'd0, 1'b0, 5'h02, 8'h23),
                              pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd1, 1'b0, 5'h03, 8'h23));
  endtask

  task automatic t_year();
    step("R6 wrap sets century", pk(6'h23, 7'h59, 7'h59, 6'h31, 3'd6, 1'b0, 5'h12, 8'h99),
                                 pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd0, 1'b1, 5'h01, 8'h00));
    step("R6 wrap clears century", pk(6'h23, 7'h59, 7'h59, 6'h31, 3'd2, 1'b1, 5'h12, 8'h99),
                                   pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd3, 1'b0, 5'h01, 8'h00));
    step("R6 bcd year carry", pk(6'h23, 7'h59, 7'h59, 6'h31, 3'd2, 1'b0, 5'h12, 8'h19),
                              pk(6'h00, 7'h00, 7'h00, 6'h01, 3'd3, 1'b0, 5'h01, 8'h20));
  endtask

  task automatic t_stop();
    set_all(6'h12, 7'h30, 7'h45, 6'h10, 3'd2, 1'b0, 5'h06, 8'h22);
    stop_i = 1'b1;
    repeat (3*SEC_CYC) @(negedge clk);
    chk("R7 frozen", now(), pk(6'h12, 7'h30, 7'h45, 6'h10, 3'd2, 1'b0, 5'h06, 8'h22));
    stop_i = 1'b0;
    repeat (START_CYC-1) @(negedge clk);
    chk("R7 no early start", 64'(sec_o), 64'h45);
    @(negedge clk);
    chk("R7 start delay", 64'(sec_o), 64'h46);
    repeat (SEC_CYC) @(negedge clk);
    chk("R7 period after start", 64'(sec_o), 64'h47);
  endtask

  task automatic t_vl();
    wr(3'd7, 8'h00);
    chk("R8 clear", 64'(vl_o), 64'd0);
    vlow_i = 1'b1; @(negedge clk); vlow_i = 1'b0;
    chk("R8 set", 64'(vl_o), 64'd1);
    repeat (4) @(negedge clk);
    chk("R8 sticky", 64'(vl_o), 64'd1);
    wr(3'd7, 8'h01);
    chk("R8 bit0 one ignored", 64'(vl_o), 64'd1);
    vlow_i = 1'b1; wr(3'd7, 8'h00); vlow_i = 1'b0;
    chk("R8 set wins", 64'(vl_o), 64'd1);
    wr(3'd7, 8'hFE);
    chk("R8 clear again", 64'(vl_o), 64'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_second_timing();
    t_carry();
    t_month();
    t_leap();
    t_year();
    t_stop();
    t_vl();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule